// File: doc/BRIEF.md
# Gated DDR Clock Forwarder

This block sends a copy of an internal clock out of the chip, and an enable input can stop and restart that copy without glitches. It does not AND the clock with the enable. It uses a double-data-rate output stage. One data value is launched for the high half of each internal clock period and a second value for the low half. For plain forwarding, the high-half value is held at 1 and the low-half value at 0, so the output reproduces the clock.

To gate the clock, the registered enable drives the high-half value while the low-half value stays at 0. A disabled cycle therefore yields a full period at 0 and never a shortened pulse. The cost is one internal clock of latency. The single-ended result also drives a complementary pair that models a differential output driver.

A user drives `en` synchronously to `clk`. Each rising edge where `en` is sampled high produces exactly one full-width high pulse, beginning at the following rising edge. The parameter `GATED` selects between enable-driven gating and free-running forwarding that ignores `en`.

Top module: `gdcf_top`

## Requirements
- R1: During each high half-period of `clk`, `fwd_clk` holds the value launched for that half. During each low half-period, it holds the low-half value, which is fixed at 0.
- R2: With `GATED`=0, the enable is ignored. From the second rising edge after reset release onward, `fwd_clk` is 1 for every high half and 0 for every low half of `clk`.
- R3: While `en` is sampled 0 at consecutive rising edges, `fwd_clk` stays at a constant 0.
- R4: When `en` is sampled 0 at rising edge k, the high half after edge k+1 is suppressed. The pulse following edge k still reflects the sample taken at edge k-1.
- R5: Every high pulse on `fwd_clk` lasts exactly half a `clk` period. This holds even when `en` changes at arbitrary times within a period.
- R6: `diff_p` always equals `fwd_clk`, and `diff_n` is always its inverse.
- R7: While `rst_n` is 0, `fwd_clk` and `diff_p` are 0 and `diff_n` is 1, whatever `en` and `clk` do.
- R8: When `en` is first sampled 1 at rising edge k, the first high pulse starts at rising edge k+1.
- R9: Over any stretch that begins and ends with the output idle, the number of high pulses on `fwd_clk` equals the number of rising edges where `en` was sampled 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Internal clock to forward |
| rst_n | input | 1 | Asynchronous active-low reset |
| en | input | 1 | Synchronous enable, sampled at rising `clk` edges |
| fwd_clk | output | 1 | Single-ended forwarded clock |
| diff_p | output | 1 | Positive leg of the complementary pair |
| diff_n | output | 1 | Negative leg of the complementary pair |

## Verification
On every cycle, the assertions check four things. The low half-period is always 0. Each high half reflects the enable sampled two half-cycles earlier, which gives the one-cycle latency. The pair legs track the forwarded clock and stay complementary, and the outputs hold their idle levels during reset. Other properties need a run over many cycles, and only the bench scenarios can show them. These are pulse width measured in time, pulse counts equal to the enabled samples, and immunity to enable changes inside a period. The same applies to the free-running variant.

// File: rtl/gdcf_pkg.sv
package gdcf_pkg;

   // complementary output pair
   typedef struct packed {
      logic pos;
      logic neg;
   } gdcf_pair_t;

   // level launched for every low half-period
   localparam logic GDCF_LOW_HALF = 1'b0;

   function automatic gdcf_pair_t gdcf_make_pair(input logic se);
      gdcf_pair_t pr;
      pr.pos = se;
      pr.neg = ~se;
      return pr;
   endfunction

endpackage

// File: rtl/gdcf_launch_ctl.sv
// Decides the value launched for each high half-period.
module gdcf_launch_ctl #(
   parameter int GATED = 1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic en,
   output logic launch_hi
);

   if (GATED != 0 && GATED != 1) begin : g_bad_gated
      $error("gdcf_launch_ctl: GATED must be 0 or 1");
   end

   if (GATED == 1) begin : g_gated
      logic en_q;
      // enable sampled only at the rising edge
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) en_q <= 1'b0;
         else        en_q <= en;
      end
      assign launch_hi = en_q;
   end else begin : g_free
      logic unused_en;
      assign unused_en = en;
      assign launch_hi = 1'b1;
   end

endmodule

// File: rtl/gdcf_ddr_cell.sv
// Behavioural DDR output stage. Each half's data is staged one half-period
// ahead (high-half value at the falling edge, low-half value at the rising
// edge), so the clock-select mux never sees a register change at the edge
// that selects it.
module gdcf_ddr_cell #(
   parameter logic RST_LEVEL = 1'b0
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d_rise,
   input  logic d_fall,
   output logic q
);

   logic hi_stage;
   logic lo_stage;

   always_ff @(negedge clk or negedge rst_n) begin
      if (!rst_n) hi_stage <= RST_LEVEL;
      else        hi_stage <= d_rise;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) lo_stage <= RST_LEVEL;
      else        lo_stage <= d_fall;
   end

   assign q = clk ? hi_stage : lo_stage;

   // R1: low half shows the low-half value sampled at the prior rising edge
   p_low_half_value_r1: assert property (@(posedge clk) disable iff (!rst_n)
      $past(rst_n) |-> (q == $past(d_fall)));

endmodule

// File: rtl/gdcf_pair_drv.sv
// Complementary pair model of a differential driver.
module gdcf_pair_drv
   import gdcf_pkg::*;
(
   input  logic       se_in,
   output gdcf_pair_t pair
);

   assign pair = gdcf_make_pair(se_in);

endmodule

// File: rtl/gdcf_top.sv
module gdcf_top
   import gdcf_pkg::*;
#(
   parameter int GATED = 1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic en,
   output logic fwd_clk,
   output logic diff_p,
   output logic diff_n
);

   logic       launch_hi;
   gdcf_pair_t pair;

   gdcf_launch_ctl #(.GATED(GATED)) u_launch (
      .clk      (clk),
      .rst_n    (rst_n),
      .en       (en),
      .launch_hi(launch_hi)
   );

   gdcf_ddr_cell #(.RST_LEVEL(1'b0)) u_ddr (
      .clk   (clk),
      .rst_n (rst_n),
      .d_rise(launch_hi),
      .d_fall(GDCF_LOW_HALF),
      .q     (fwd_clk)
   );

   gdcf_pair_drv u_pair (
      .se_in(fwd_clk),
      .pair (pair)
   );

   assign diff_p = pair.pos;
   assign diff_n = pair.neg;

   // R4 / R8: high half carries the launch value seen one half earlier
   p_gate_latency_r4: assert property (@(negedge clk) disable iff (!rst_n)
      $past(rst_n) |-> (fwd_clk == $past(launch_hi)));

   // R3: low half is always idle
   p_low_idle_r3: assert property (@(posedge clk) disable iff (!rst_n)
      !fwd_clk);

   // R6: pair tracks the forwarded clock, legs complementary
   p_pair_track_r6: assert property (@(negedge clk) disable iff (!rst_n)
      (diff_p == fwd_clk) && (diff_n != diff_p));

   // R7: idle levels while reset is held
   p_reset_idle_r7: assert property (@(posedge clk)
      !rst_n |-> (!fwd_clk && !diff_p && diff_n));

endmodule

// File: tb/gdcf_top_tb.sv
`timescale 1ns/1ps
module gdcf_top_tb;

   logic clk;
   logic rst_n;
   logic en;
   logic fwd, dp, dn;
   logic pl_fwd, pl_p, pl_n;

   int checks = 0;
   int errors = 0;
   logic prev_en = 1'b0;

   int pulses = 0;
   int runts  = 0;
   int en_hi  = 0;
   realtime t_rise = 0.0;

   gdcf_top #(.GATED(1)) u_dut (
      .clk(clk), .rst_n(rst_n), .en(en),
      .fwd_clk(fwd), .diff_p(dp), .diff_n(dn)
   );

   gdcf_top #(.GATED(0)) u_plain (
      .clk(clk), .rst_n(rst_n), .en(1'b0),
      .fwd_clk(pl_fwd), .diff_p(pl_p), .diff_n(pl_n)
   );

   initial begin
      clk = 1'b0;
      forever #2 clk = ~clk;
   end

   // pulse counting and width measurement on the gated output
   always @(posedge fwd) begin
      t_rise = $realtime;
      pulses++;
   end
   always @(negedge fwd) begin
      if (rst_n) begin
         realtime w;
         w = $realtime - t_rise;
         if (w < 1.99 || w > 2.01) runts++;
      end
   end
   always @(posedge clk) begin
      if (rst_n && en) en_hi++;
   end

   task automatic chk(input bit ok, input string tag, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   // one full cycle; caller stands just after a falling edge
   task automatic run_cycle(input logic e, input string tag);
      en = e;
      @(posedge clk); #1;
      chk(fwd == prev_en, {tag, " high half"}, fwd, prev_en);
      chk(dp == fwd && dn == ~fwd, "R6 pair in high half", {dp, dn}, {fwd, ~fwd});
      @(negedge clk); #1;
      chk(fwd == 1'b0, "R1 low half zero", fwd, 0);
      chk(dp == fwd && dn == ~fwd, "R6 pair in low half", {dp, dn}, {fwd, ~fwd});
      prev_en = e;
   endtask

   task automatic t_reset();
      @(posedge clk); #1;
      chk(fwd == 0 && dp == 0 && dn == 1, "R7 reset idle (high phase)", {fwd, dp, dn}, 3'b001);
      @(negedge clk); #1;
      chk(pl_fwd == 0 && pl_n == 1, "R7 reset idle plain", {pl_fwd, pl_n}, 2'b01);
   endtask

   task automatic t_enable_rise();
      run_cycle(1'b0, "R3 idle");
      run_cycle(1'b1, "R8 sample edge no pulse yet");
      run_cycle(1'b1, "R8 first pulse");
      run_cycle(1'b1, "R1 steady pulse");
   endtask

   task automatic t_disable();
      run_cycle(1'b0, "R4 current pulse kept");
      run_cycle(1'b0, "R4 next pulse suppressed");
      for (int i = 0; i < 4; i++) run_cycle(1'b0, "R3 constant zero");
   endtask

   task automatic t_pattern();
      logic [15:0] pat = 16'b1011_0010_0111_0001;
      int p0;
      p0 = pulses;
      for (int i = 0; i < 16; i++) run_cycle(pat[i], "R9 pattern");
      run_cycle(1'b0, "R9 flush");
      run_cycle(1'b0, "R9 flush");
      chk(pulses - p0 == $countones(pat), "R9 pulse count", pulses - p0, $countones(pat));
   endtask

   task automatic t_runt();
      int p0, e0;
      p0 = pulses;
      e0 = en_hi;
      for (int i = 0; i < 10; i++) begin
         @(posedge clk); #0.3;
         en = ~en;
         if (i % 3 == 0) begin
            #1.1 en = ~en;
         end
         @(negedge clk); #0.9;
         if (i % 2 == 1) en = ~en;
      end
      @(negedge clk); #1;
      en = 1'b0;
      repeat (3) @(posedge clk);
      @(negedge clk); #1;
      prev_en = 1'b0;
      chk(runts == 0, "R5 no runt pulse", runts, 0);
      chk(pulses - p0 == en_hi - e0, "R9 count under mid-cycle toggles",
          pulses - p0, en_hi - e0);
      chk(pulses - p0 > 0, "R5 pulses produced", pulses - p0, 1);
   endtask

   task automatic t_plain();
      for (int i = 0; i < 4; i++) begin
         @(posedge clk); #1;
         chk(pl_fwd == 1'b1, "R2 plain high half", pl_fwd, 1);
         chk(pl_p == 1 && pl_n == 0, "R6 plain pair", {pl_p, pl_n}, 2'b10);
         @(negedge clk); #1;
         chk(pl_fwd == 1'b0, "R2 plain low half", pl_fwd, 0);
      end
   endtask

   task automatic t_reset_mid();
      run_cycle(1'b1, "R8 re-enable");
      run_cycle(1'b1, "R1 pulse before reset");
      rst_n = 1'b0;
      #1;
      chk(fwd == 0 && dp == 0 && dn == 1, "R7 reset asserted", {fwd, dp, dn}, 3'b001);
      @(posedge clk); #1;
      chk(fwd == 0 && dn == 1, "R7 reset holds in high half", {fwd, dn}, 2'b01);
      @(negedge clk); #1;
      rst_n = 1'b1;
      prev_en = 1'b0;
      run_cycle(1'b1, "R8 after reset no pulse");
      run_cycle(1'b0, "R8 after reset first pulse");
      run_cycle(1'b0, "R4 suppressed after reset");
   endtask

   initial begin
      rst_n = 1'b1;
      en = 1'b0;
      #1 rst_n = 1'b0;
      t_reset();
      @(negedge clk); #1;
      rst_n = 1'b1;
      prev_en = 1'b0;
      t_enable_rise();
      t_disable();
      t_pattern();
      t_plain();
      t_runt();
      t_reset_mid();
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      #800000;
      errors++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule